// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block performs read lookups in a small two-way set-associative cache that guesses, per set, which way will hold the requested line. When a request is accepted, the address is registered. In the next cycle the data of the guessed way is already routed to the read-data output, and only that way's tag is compared. If the guess is right, the response is valid in that cycle. If it is wrong, the other way is compared one cycle later. If neither way holds the line, a refill request goes out to the lower level. The returned line is written into the least recently used way and is forwarded to the requester in the same cycle.

Tags, data, valid bits, the per-set guess and the per-set LRU bit are held in register arrays inside the block. The three outcome strobes (fast hit, slow hit, miss) are visible at the ports, so a system can count how often the guess is right. The block serves one request at a time. It accepts a new request only when it is idle.

Top module: `wp_cache_lookup`

## Requirements
- R1: After reset, reqReady is high and rspValid, refillReq, hitFast, hitSlow and miss are low. Every line is invalid, so the first access to any address misses.
- R2: When the guessed way of the addressed set holds the tag, rspValid and hitFast are high in the first cycle after the accepting clock edge, and rspData is the stored word.
- R3: When the line sits in the way that was not guessed, rspValid and hitSlow are high in the second cycle after acceptance, exactly one cycle later than a correct guess, and rspData is the stored word.
- R4: After a slow hit, the set's guess points at the way that hit, so an immediate repeat of the same address is a fast hit.
- R5: When neither way holds the tag, miss pulses high for one cycle in the second cycle after acceptance. From the next cycle on, refillReq stays high with refillAddr equal to the request address until refillValid is seen.
- R6: The refill overwrites the way named by the set's LRU bit. Every hit or refill sets the LRU bit to the other way of that set.
- R7: In the cycle refillValid is high during a refill, rspValid is high, rspData equals refillData, and hitFast, hitSlow and miss are low. The filled way becomes the set's guess.
- R8: reqReady is low from the cycle after acceptance until the response cycle, inclusive. At most one of hitFast, hitSlow and miss is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request present |
| reqAddr | input | ADDR_W | Word address; low IDX_W bits select the set, the rest is the tag |
| reqReady | output | 1 | Block idle and able to accept a request |
| rspValid | output | 1 | rspData holds the requested word |
| rspData | output | DATA_W | Read data |
| hitFast | output | 1 | Hit in the guessed way |
| hitSlow | output | 1 | Hit in the other way, one cycle later |
| miss | output | 1 | Neither way holds the line |
| refillReq | output | 1 | Line wanted from the lower level |
| refillAddr | output | ADDR_W | Address of the wanted line |
| refillValid | input | 1 | refillData holds the wanted line |
| refillData | input | DATA_W | Line returned by the lower level |

## Verification
The assertions check the local timing on every cycle. A fast hit must follow acceptance by one cycle and a slow hit by two. A miss must be followed by a held refill request with a stable address. A refill response must carry no hit flag. The outcome strobes must stay mutually exclusive, and the block must stay busy after acceptance. Whether each outcome is the correct one depends on history across many accesses: the guess moving after a slow hit, the LRU victim choice, and valid lines surviving or being evicted. Only the bench shows this. It sweeps every address of a small configuration and runs conflict sequences against its own model of the guess and LRU bits.

// File: rtl/wp_lookup_pkg.sv
package wp_lookup_pkg;

  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRED = 2'd1,
    ST_ALT  = 2'd2,
    ST_FILL = 2'd3
  } lookupState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // register request address
    logic selAlt;      // steer read mux to the non-guessed way
    logic hitFastUpd;  // guessed way hit: refresh LRU
    logic hitSlowUpd;  // other way hit: move guess, refresh LRU
    logic fillWrite;   // install refill line in victim way
    logic fillResp;    // forward refill data to the response
  } lookupStrobe_t;

endpackage

// File: rtl/wp_lookup_dpath.sv
module wp_lookup_dpath
  import wp_lookup_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  lookupStrobe_t     strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] refillData,
  output logic              predMatch,
  output logic              altMatch,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] refillAddr
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;

  logic [ADDR_W-1:0] addrQ;
  logic [IDX_W-1:0]  idxQ;
  logic [TAG_W-1:0]  tagQ;

  logic [WAYS-1:0]   validArr [SETS];
  logic [TAG_W-1:0]  tagArr   [SETS][WAYS];
  logic [DATA_W-1:0] dataArr  [SETS][WAYS];
  logic [SETS-1:0]   predBit;
  logic [SETS-1:0]   lruBit;

  logic              predWay;
  logic              altWay;
  logic              victimWay;
  logic              readWay;
  logic [WAYS-1:0]   wayHit;

  assign idxQ      = addrQ[IDX_W-1:0];
  assign tagQ      = addrQ[ADDR_W-1:IDX_W];
  assign predWay   = predBit[idxQ];
  assign altWay    = ~predWay;
  assign victimWay = lruBit[idxQ];

  // per-way tag compare
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayHit[w] = validArr[idxQ][w] && (tagArr[idxQ][w] == tagQ);
  end

  assign predMatch = wayHit[predWay];
  assign altMatch  = wayHit[altWay];

  // read mux is steered by the guess, independent of the compare result
  assign readWay    = strobe.selAlt ? altWay : predWay;
  assign rspData    = strobe.fillResp ? refillData : dataArr[idxQ][readWay];
  assign refillAddr = addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      predBit <= '0;
      lruBit  <= '0;
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
      end
    end else begin
      if (strobe.capture) begin
        addrQ <= reqAddr;
      end
      if (strobe.hitFastUpd) begin
        lruBit[idxQ] <= altWay;
      end
      if (strobe.hitSlowUpd) begin
        predBit[idxQ] <= altWay;
        lruBit[idxQ]  <= predWay;
      end
      if (strobe.fillWrite) begin
        validArr[idxQ][victimWay] <= 1'b1;
        predBit[idxQ]             <= victimWay;
        lruBit[idxQ]              <= ~victimWay;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWrite) begin
      tagArr[idxQ][victimWay]  <= tagQ;
      dataArr[idxQ][victimWay] <= refillData;
    end
  end

endmodule

// File: rtl/wp_lookup_ctrl.sv
module wp_lookup_ctrl
  import wp_lookup_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          predMatch,
  input  logic          altMatch,
  input  logic          refillValid,
  output logic          reqReady,
  output logic          rspValid,
  output logic          hitFast,
  output logic          hitSlow,
  output logic          miss,
  output logic          refillReq,
  output lookupStrobe_t strobe
);

  lookupState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD    = stateQ;
    strobe    = '0;
    reqReady  = 1'b0;
    rspValid  = 1'b0;
    hitFast   = 1'b0;
    hitSlow   = 1'b0;
    miss      = 1'b0;
    refillReq = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady       = 1'b1;
        strobe.capture = reqValid;
        if (reqValid) begin
          stateD = ST_PRED;
        end
      end
      ST_PRED: begin
        if (predMatch) begin
          rspValid          = 1'b1;
          hitFast           = 1'b1;
          strobe.hitFastUpd = 1'b1;
          stateD            = ST_IDLE;
        end else begin
          stateD = ST_ALT;
        end
      end
      ST_ALT: begin
        strobe.selAlt = 1'b1;
        if (altMatch) begin
          rspValid          = 1'b1;
          hitSlow           = 1'b1;
          strobe.hitSlowUpd = 1'b1;
          stateD            = ST_IDLE;
        end else begin
          miss   = 1'b1;
          stateD = ST_FILL;
        end
      end
      ST_FILL: begin
        refillReq       = 1'b1;
        strobe.fillResp = 1'b1;
        if (refillValid) begin
          rspValid         = 1'b1;
          strobe.fillWrite = 1'b1;
          stateD           = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup
  import wp_lookup_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              hitFast,
  output logic              hitSlow,
  output logic              miss,
  output logic              refillReq,
  output logic [ADDR_W-1:0] refillAddr,
  input  logic              refillValid,
  input  logic [DATA_W-1:0] refillData
);

  lookupStrobe_t strobe;
  logic          predMatch;
  logic          altMatch;

  wp_lookup_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .predMatch   (predMatch),
    .altMatch    (altMatch),
    .refillValid (refillValid),
    .reqReady    (reqReady),
    .rspValid    (rspValid),
    .hitFast     (hitFast),
    .hitSlow     (hitSlow),
    .miss        (miss),
    .refillReq   (refillReq),
    .strobe      (strobe)
  );

  wp_lookup_dpath #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .refillData (refillData),
    .predMatch  (predMatch),
    .altMatch   (altMatch),
    .rspData    (rspData),
    .refillAddr (refillAddr)
  );

endmodule

// File: rtl/wp_lookup_checker.sv
module wp_lookup_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              hitFast,
  input logic              hitSlow,
  input logic              miss,
  input logic              refillReq,
  input logic [ADDR_W-1:0] refillAddr,
  input logic              refillValid,
  input logic [DATA_W-1:0] refillData
);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hitFast, hitSlow, miss}));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_fast_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    hitFast |-> (rspValid && $past(reqValid && reqReady)));

  assert_slow_two_cycles_R3: assert property (@(posedge clk) disable iff (!rstN)
    hitSlow |-> (rspValid && $past(reqValid && reqReady, 2)));

  assert_miss_starts_refill_R5: assert property (@(posedge clk) disable iff (!rstN)
    miss |=> refillReq);

  assert_refill_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (refillReq && !refillValid) |=> (refillReq && $stable(refillAddr)));

  assert_fill_forward_R7: assert property (@(posedge clk) disable iff (!rstN)
    (refillReq && refillValid) |-> (rspValid && !hitFast && !hitSlow && rspData == refillData));

endmodule

bind wp_cache_lookup wp_lookup_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .rspValid    (rspValid),
  .rspData     (rspData),
  .hitFast     (hitFast),
  .hitSlow     (hitSlow),
  .miss        (miss),
  .refillReq   (refillReq),
  .refillAddr  (refillAddr),
  .refillValid (refillValid),
  .refillData  (refillData)
);

// File: tb/tb_wp_cache_lookup.sv
`timescale 1ns/1ps
module tb_wp_cache_lookup;

  localparam int ADDR_W = 6;
  localparam int IDX_W  = 2;
  localparam int DATA_W = 16;
  localparam int SETS   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqReady;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic              hitFast;
  logic              hitSlow;
  logic              miss;
  logic              refillReq;
  logic [ADDR_W-1:0] refillAddr;
  logic              refillValid = 1'b0;
  logic [DATA_W-1:0] refillData = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench reference of per-set state
  bit mValid [SETS][2];
  int mTag   [SETS][2];
  int mPred  [SETS];
  int mLru   [SETS];

  always #2.5 clk = ~clk;

  wp_cache_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .hitFast(hitFast), .hitSlow(hitSlow), .miss(miss),
    .refillReq(refillReq), .refillAddr(refillAddr),
    .refillValid(refillValid), .refillData(refillData)
  );

  function automatic logic [DATA_W-1:0] memWord(input logic [ADDR_W-1:0] a);
    return DATA_W'((32'(a) * 32'h9E37) ^ 32'h5A5A);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // class: 0 fast hit, 1 slow hit, 2 miss
  task automatic doAccess(input logic [ADDR_W-1:0] a, input string tag);
    int s = int'(a[IDX_W-1:0]);
    int t = int'(a[ADDR_W-1:IDX_W]);
    int p = mPred[s];
    int o = 1 - p;
    int expCls;
    int d = int'(a) % 3;
    int cyc = 0, fw = 0, rCyc = 0, missCyc = 0;
    bit gotRsp = 0, sawMiss = 0, busyOk = 1, addrOk = 1;
    int rF = 0, rS = 0, rM = 0, actCls;
    logic [DATA_W-1:0] rData = '0;
    string lbl;

    if (mValid[s][p] && mTag[s][p] == t) begin
      expCls = 0;
      mLru[s] = o;
    end else if (mValid[s][o] && mTag[s][o] == t) begin
      expCls = 1;
      mPred[s] = o;
      mLru[s] = p;
    end else begin
      int v = mLru[s];
      expCls = 2;
      mValid[s][v] = 1;
      mTag[s][v] = t;
      mPred[s] = v;
      mLru[s] = 1 - v;
    end
    if (tag != "") lbl = tag;
    else lbl = (expCls == 0) ? "R2" : (expCls == 1) ? "R3" : "R5";

    @(negedge clk);
    refillValid = 1'b0;
    reqValid = 1'b1;
    reqAddr = a;
    #1;
    check(reqReady == 1'b1, "R8", "ready before request", reqReady, 1);
    @(posedge clk);
    while (!gotRsp && cyc < 64) begin
      @(negedge clk);
      reqValid = 1'b0;
      cyc++;
      if (refillReq) begin
        if (fw == d) begin
          refillValid = 1'b1;
          refillData = memWord(refillAddr);
        end else begin
          fw++;
          refillValid = 1'b0;
        end
      end else begin
        refillValid = 1'b0;
      end
      #1;
      if (reqReady) busyOk = 0;
      if (refillReq && refillAddr != a) addrOk = 0;
      if (miss) begin
        if (sawMiss) missCyc = -1;
        else missCyc = cyc;
        sawMiss = 1;
      end
      if (rspValid) begin
        gotRsp = 1;
        rCyc = cyc;
        rData = rspData;
        rF = int'(hitFast);
        rS = int'(hitSlow);
        rM = int'(miss);
      end
    end

    check(gotRsp, lbl, "response seen (watchdog)", gotRsp, 1);
    check(busyOk, "R8", "reqReady low while busy", busyOk, 1);
    check(rF + rS + rM <= 1, "R8", "exclusive flags", rF + rS + rM, 1);
    actCls = sawMiss ? 2 : (rS != 0) ? 1 : (rF != 0) ? 0 : 3;
    check(actCls == expCls, lbl, "outcome class", actCls, expCls);
    check(rData == memWord(a), (expCls == 2) ? "R7" : lbl, "read data", rData, memWord(a));
    if (expCls == 0) begin
      check(rCyc == 1 && rF == 1, lbl, "fast hit cycle", rCyc, 1);
    end else if (expCls == 1) begin
      check(rCyc == 2 && rS == 1, lbl, "slow hit cycle", rCyc, 2);
    end else begin
      check(missCyc == 2, "R5", "miss pulse cycle", missCyc, 2);
      check(addrOk, "R5", "refill address", addrOk, 1);
      check(rCyc == 3 + d, "R7", "refill response cycle", rCyc, 3 + d);
      check(rF == 0 && rS == 0 && rM == 0, "R7", "no flags on refill response", rF + rS + rM, 0);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      mPred[s] = 0;
      mLru[s] = 0;
      for (int w = 0; w < 2; w++) begin
        mValid[s][w] = 0;
        mTag[s][w] = 0;
      end
    end
    repeat (3) @(negedge clk);
    #1;
    check(reqReady == 1 && rspValid == 0 && refillReq == 0 && hitFast == 0
          && hitSlow == 0 && miss == 0, "R1", "outputs in reset",
          {reqReady, rspValid, refillReq, hitFast, hitSlow, miss}, 6'b100000);
    @(negedge clk);
    rstN = 1'b1;

    // R1: first touch of every address misses; also fills and evicts
    for (int a = 0; a < 64; a++) begin
      doAccess(ADDR_W'(a), (a < SETS) ? "R1" : "");
    end

    // directed conflict sequences per set
    for (int s = 0; s < SETS; s++) begin
      logic [ADDR_W-1:0] aA = ADDR_W'((1 << IDX_W) * 1 + s);
      logic [ADDR_W-1:0] aB = ADDR_W'((1 << IDX_W) * 5 + s);
      logic [ADDR_W-1:0] aC = ADDR_W'((1 << IDX_W) * 9 + s);
      doAccess(aA, "");
      doAccess(aB, "");
      doAccess(aA, "");      // slow or fast per history
      doAccess(aA, "R4");    // guess must now be A's way
      doAccess(aB, "R3");    // other way: slow hit
      doAccess(aB, "R4");
      doAccess(aA, "R3");
      doAccess(aC, "R6");    // victim is B's way (LRU)
      doAccess(aA, "R6");    // A must survive
      doAccess(aB, "R6");    // B was evicted
      doAccess(aB, "R2");
    end

    // mixed pattern over three tags per set
    for (int i = 0; i < 600; i++) begin
      int tg = ((i * 5) + (i >> 2)) % 3 + ((i >> 6) % 2) * 4;
      int st = (i * 3 + (i >> 3)) % SETS;
      doAccess(ADDR_W'(tg * SETS + st), "");
    end

    finishRun();
  end

endmodule